// File: doc/BRIEF.md
# Interrupt Status, Mask and Poll Register Bank

This block is the event-reporting corner of a network controller's register file. Hardware event pulses set sticky flags in an interrupt status register. A host read of that register returns the flags and clears them in the same access. A host-writable mask register decides which flags may pull the active-low interrupt line. A third register, which the host can only read, holds a per-cycle copy of three live status signals. Hosts that poll instead of taking interrupts can read it without disturbing it.

The host side is a byte-wide register bus with a 4-bit address, a read strobe, a write strobe and write data. Read data is combinational while the read strobe is high. The read side effect, clearing the status flags, takes place at the clock edge that ends a one-cycle read. The hardware reset is asynchronous and active-low, and its release is synchronised inside the block. A one-cycle software-reset pulse clears every register at the next clock edge.

Top module: `irq_regbank`

## Requirements
- R1: A high bit on `evt` sets the matching status bit at the next clock edge. The bit stays set until a status read or a reset clears it. The status bit order, from bit 7 down to bit 0, is: jabber, babble, collision error, receive collision count overflow, runt count overflow, missed count overflow, receive done, transmit done.
- R2: A read at address 8 returns the status byte. At the end of that read cycle the status is cleared, so a second read with no new events returns 0.
- R3: A write to address 8 does not change the status register.
- R4: Address 9 is the mask register. A write stores `wdata`, and a read returns the stored value. Mask bit n belongs to status bit n.
- R5: `irq_n` is 0 exactly when some status bit is 1 while its mask bit is 0. When every set status bit is masked, `irq_n` is 1.
- R6: A read at address 10 returns the poll byte: bit 7 is the transmit-status-valid input, bit 6 is the transmit FIFO request and bit 5 is the receive FIFO request, each as sampled at the previous clock edge. Bits 4 to 0 read 0. Reading the poll byte does not change it.
- R7: While `rst_n` is low, status, mask and poll are all 0 and `irq_n` is 1.
- R8: A cycle with `sw_rst` high clears status, mask and poll at that clock edge. The clear takes priority over events, writes and sampling in the same cycle.
- R9: An event that arrives in the same cycle as a status read leaves its bit set after the read. The read returns the value held before that edge.
- R10: A read at any address other than 8, 9 or 10 returns 0 and changes no register. `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset pulse |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| evt | input | 8 | Event pulses, one per status bit |
| tx_stat_valid | input | 1 | Live transmit-status-valid flag |
| tx_fifo_req | input | 1 | Live transmit FIFO request |
| rx_fifo_req | input | 1 | Live receive FIFO request |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `rd_en` and `wr_en` are each held for a single cycle per access and never name the same address in the same cycle. They also assume that `evt` is quiet whenever a stability property on the status register is meant to apply. The bench drives every access as a one-cycle strobe and changes its inputs just after a clock edge. Events are raised only in their own pulse cycles, except for the deliberate read-collision case. The software reset is pulsed while events and writes are idle, apart from the one case that tests the priority of the clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned POLL_W    = 3;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 4'd8;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 4'd9;
  localparam logic [ADDR_W-1:0] POLL_ADDR = 4'd10;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic         rd_clr,
  input  logic [W-1:0] evt,
  output logic [W-1:0] st_q
);
  logic [W-1:0] st_d;

  always_comb begin
    if (sw_rst) st_d = '0;
    else        st_d = (rd_clr ? '0 : st_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  // R1
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !sw_rst) |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R9
  evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !sw_rst) |=> ((st_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic         ld,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  logic         en;
  logic [W-1:0] mask_d;

  always_comb begin
    en     = ld | sw_rst;
    mask_d = sw_rst ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '0;
    else if (en) mask_q <= mask_d;
  end

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !sw_rst) |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/irq_poll_reg.sv
module irq_poll_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic [W-1:0] live,
  output logic [W-1:0] poll_q
);
  logic [W-1:0] poll_d;

  always_comb poll_d = sw_rst ? '0 : live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) poll_q <= '0;
    else        poll_q <= poll_d;
  end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] evt,
  input  logic              tx_stat_valid,
  input  logic              tx_fifo_req,
  input  logic              rx_fifo_req,
  output logic              irq_n
);
  localparam int unsigned PAD_W = DATA_W - POLL_W;

  logic [1:0]        rsync_q;
  logic              rst_i_n;
  logic              rd_stat, wr_mask;
  logic [DATA_W-1:0] stat_q, mask_q;
  logic [POLL_W-1:0] poll_q, live;
  logic [DATA_W-1:0] poll_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  always_comb begin
    rd_stat   = rd_en && (addr == STAT_ADDR);
    wr_mask   = wr_en && (addr == MASK_ADDR);
    live      = {tx_stat_valid, tx_fifo_req, rx_fifo_req};
    poll_byte = {poll_q, {PAD_W{1'b0}}};
  end

  irq_status_reg #(.W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_i_n), .sw_rst(sw_rst),
    .rd_clr(rd_stat), .evt(evt), .st_q(stat_q));

  irq_mask_reg #(.W(DATA_W)) u_mask (
    .clk(clk), .rst_n(rst_i_n), .sw_rst(sw_rst),
    .ld(wr_mask), .wdata(wdata), .mask_q(mask_q));

  irq_poll_reg #(.W(POLL_W)) u_poll (
    .clk(clk), .rst_n(rst_i_n), .sw_rst(sw_rst),
    .live(live), .poll_q(poll_q));

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        STAT_ADDR: rdata = stat_q;
        MASK_ADDR: rdata = mask_q;
        POLL_ADDR: rdata = poll_byte;
        default:   rdata = '0;
      endcase
    end
  end

  always_comb irq_n = ~|(stat_q & ~mask_q);

  // R3
  stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_en && addr == STAT_ADDR && !rd_en && !sw_rst && evt == '0) |=> $stable(stat_q));

  // R5
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mask_q == '1) |-> irq_n);

  // R8
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    sw_rst |=> (stat_q == '0 && mask_q == '0 && poll_q == '0));

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && !wr_en && !sw_rst && evt == '0 && addr != STAT_ADDR)
      |=> ($stable(stat_q) && $stable(mask_q)));
endmodule

// File: tb/tb_irq_regbank.sv
module tb_irq_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_rst = 1'b0;
  logic [3:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0, rdata, evt = '0;
  logic       tx_stat_valid = 1'b0, tx_fifo_req = 1'b0, rx_fifo_req = 1'b0;
  logic       irq_n;
  int         errs = 0, checks = 0;
  logic [7:0] d;

  // {mask, evt, 7'b0, expected irq_n}
  localparam logic [23:0] VEC [7] = '{
    {8'h00, 8'h01, 8'h00}, {8'h01, 8'h01, 8'h01}, {8'hFE, 8'h01, 8'h00},
    {8'h80, 8'h80, 8'h01}, {8'h7F, 8'hC0, 8'h00}, {8'hFF, 8'hFF, 8'h01},
    {8'h00, 8'h00, 8'h01}};

  irq_regbank dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    addr = a; wdata = v; wr_en = 1'b1; cyc(); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1; #1; v = rdata; cyc(); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    evt = e; cyc(); evt = '0;
  endtask

  initial begin
    #(200000 * 20);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1;
    chk("R7 irq_n in reset", {7'b0, irq_n}, 8'h01);
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    rd(4'd8, d);  chk("R7 status after reset", d, 8'h00);
    rd(4'd9, d);  chk("R7 mask after reset", d, 8'h00);
    rd(4'd10, d); chk("R7 poll after reset", d, 8'h00);
    chk("R10 idle rdata", rdata, 8'h00);

    for (int i = 0; i < 7; i++) begin
      wr(4'd9, VEC[i][23:16]);
      rd(4'd9, d); chk("R4 mask readback", d, VEC[i][23:16]);
      pulse(VEC[i][15:8]);
      chk("R5 irq_n", {7'b0, irq_n}, {7'b0, VEC[i][0]});
      cyc();
      rd(4'd8, d); chk("R1 sticky status", d, VEC[i][15:8]);
      chk("R2 irq_n after clear", {7'b0, irq_n}, 8'h01);
      rd(4'd8, d); chk("R2 cleared on read", d, 8'h00);
    end
    wr(4'd9, 8'h00);

    pulse(8'h04);
    wr(4'd8, 8'hFF); wr(4'd8, 8'h00);
    rd(4'd8, d); chk("R3 write ignored", d, 8'h04);

    tx_stat_valid = 1'b1; tx_fifo_req = 1'b0; rx_fifo_req = 1'b1; cyc();
    rd(4'd10, d); chk("R6 poll A0", d, 8'hA0);
    rd(4'd10, d); chk("R6 poll unchanged by read", d, 8'hA0);
    tx_stat_valid = 1'b0; tx_fifo_req = 1'b1; rx_fifo_req = 1'b0; cyc();
    rd(4'd10, d); chk("R6 poll 40", d, 8'h40);

    pulse(8'h02);
    evt = 8'h08; addr = 4'd8; rd_en = 1'b1; #1; d = rdata;
    cyc(); rd_en = 1'b0; evt = '0;
    chk("R9 read returns old", d, 8'h02);
    rd(4'd8, d); chk("R9 event kept", d, 8'h08);

    pulse(8'h10);
    rd(4'd3, d);  chk("R10 unmapped 3", d, 8'h00);
    rd(4'd15, d); chk("R10 unmapped 15", d, 8'h00);
    rd(4'd8, d);  chk("R10 status untouched", d, 8'h10);

    wr(4'd9, 8'h55); pulse(8'h01);
    tx_stat_valid = 1'b1; tx_fifo_req = 1'b1; rx_fifo_req = 1'b1;
    sw_rst = 1'b1; evt = 8'h02; cyc(); sw_rst = 1'b0; evt = '0;
    tx_stat_valid = 1'b0; tx_fifo_req = 1'b0; rx_fifo_req = 1'b0;
    rd(4'd10, d); chk("R8 poll cleared", d, 8'h00);
    rd(4'd9, d);  chk("R8 mask cleared", d, 8'h00);
    rd(4'd8, d);  chk("R8 status cleared", d, 8'h00);
    chk("R8 irq_n", {7'b0, irq_n}, 8'h01);

    pulse(8'h20); wr(4'd9, 8'h0F);
    chk("R5 irq before hw reset", {7'b0, irq_n}, 8'h00);
    rst_n = 1'b0; #3;
    chk("R7 irq_n async", {7'b0, irq_n}, 8'h01);
    cyc(); rst_n = 1'b1; repeat (4) cyc();
    rd(4'd8, d); chk("R7 status after hw reset", d, 8'h00);
    rd(4'd9, d); chk("R7 mask after hw reset", d, 8'h00);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule